// File: doc/BRIEF.md
# Configurable Parallel Prefix Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, and returns a WIDTH-bit sum and a carry-out. It is purely combinational: no clock, no reset and no handshake. A result is valid as soon as the inputs settle. It is meant to sit inside a datapath stage whose registers belong to the caller.

The carry logic is a parallel prefix tree. First, each bit forms a generate term (the AND of the operand bits) and a propagate term (the XOR of the operand bits). Next, a network of two-input combine cells merges adjacent spans. Finally, each sum bit XORs its propagate term with the carry into its position. The carry-in enters the tree as the generate of an imaginary position below bit 0. It is merged into bit 0 before the tree starts, so every prefix the tree produces already includes it.

A compile-time parameter picks one of four tree shapes:
- Kogge-Stone: log2 W levels, fanout 2.
- Sklansky: log2 W levels, fanout doubling each level.
- Brent-Kung: 2·log2 W − 1 levels, with an up-sweep followed by a down-sweep.
- Han-Carlson: log2 W + 1 levels. A Kogge-Stone tree runs over the odd bits, then one extra level fills in the even bits.

All four shapes use the same combine cell. Where a span already reaches the carry-in position, the cell is instantiated in its generate-only form.

Top module: `pfx_adder`

## Requirements
- R1: For every input, {cout, sum} equals a + b + cin taken as an unsigned (WIDTH+1)-bit value.
- R2: The TOPO parameter encodes the tree as 0 = Kogge-Stone, 1 = Brent-Kung, 2 = Sklansky, 3 = Han-Carlson. All four encodings give identical outputs for identical inputs.
- R3: When a XOR b is all ones and cin is 1, sum is all zeros and cout is 1. The carry-in travels the full width.
- R4: With a = 0 and b = 0, the output is sum = 0 and cout = 0 when cin = 0, and sum = 1 and cout = 0 when cin = 1.
- R5: cout is 1 whenever the top bits of a and b are both 1. cout is 0 whenever both top bits are 0.
- R6: With b = 0 and cin = 0, sum equals a and cout is 0.
- R7: R1 holds for any power-of-two WIDTH of 2 or more, both at the default of 64 and at a narrow width such as 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of a + b + cin |
| cout | output | 1 | Carry out of the top bit |

## Verification
The carry-in injection and the carry-out resolve in the same evaluation when every bit propagates. In that case the carry injected below bit 0 must cross every prefix level and leave as cout, while every sum bit flips to zero. This situation is provoked with all-ones against zero, and with complementary alternating patterns, both with cin set. The sum and cout are judged against a behavioural sum for all four tree shapes at 64 and at 8 bits. Random and table vectors then compare each shape against the same behavioural sum.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {
    TOPO_KOGGE_STONE = 2'd0,
    TOPO_BRENT_KUNG  = 2'd1,
    TOPO_SKLANSKY    = 2'd2,
    TOPO_HAN_CARLSON = 2'd3
  } topo_e;

  // Number of combine levels for a tree over 2**lg lanes.
  function automatic int topo_levels(topo_e t, int lg);
    case (t)
      TOPO_BRENT_KUNG:  return 2 * lg - 1;
      TOPO_HAN_CARLSON: return lg + 1;
      default:          return lg;
    endcase
  endfunction

  // Lane that lane i merges with at level lvl (1-based), or -1 for a plain wire.
  function automatic int partner(topo_e t, int lg, int lvl, int i);
    int d;
    int k;
    int dk;
    d = 1 << (lvl - 1);
    case (t)
      TOPO_KOGGE_STONE: begin
        if (lvl <= lg && i >= d) return i - d;
      end
      TOPO_SKLANSKY: begin
        if (lvl <= lg && ((i >> (lvl - 1)) & 1) == 1)
          return ((i >> lvl) << lvl) + d - 1;
      end
      TOPO_BRENT_KUNG: begin
        if (lvl <= lg) begin
          if (((i + 1) % (2 * d)) == 0) return i - d;
        end else begin
          k  = 2 * lg - lvl;
          dk = 1 << (k - 1);
          if (k >= 1 && ((i + 1) % (2 * dk)) == dk && i >= 2 * dk) return i - dk;
        end
      end
      default: begin
        if (lvl == 1) begin
          if ((i % 2) == 1) return i - 1;
        end else if (lvl <= lg) begin
          if ((i % 2) == 1 && i >= d) return i - d;
        end else if (lvl == lg + 1) begin
          if ((i % 2) == 0 && i >= 2) return i - 1;
        end
      end
    endcase
    return -1;
  endfunction

  // Lowest lane covered by the span held in lane i after level lvl.
  function automatic int span_low(topo_e t, int lg, int lvl, int i);
    int j;
    if (lvl == 0) return i;
    j = partner(t, lg, lvl, i);
    if (j < 0) return span_low(t, lg, lvl - 1, i);
    return span_low(t, lg, lvl - 1, j);
  endfunction

endpackage

// File: rtl/pfx_pg.sv
module pfx_pg #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] g,
  output logic [WIDTH-1:0] p
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/pfx_cell.sv
module pfx_cell #(
  parameter bit GRAY = 1'b0
) (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_out,
  output logic p_out
);
  assign g_out = g_hi | (p_hi & g_lo);
  if (GRAY) begin : g_gray
    // Span reaches the carry-in lane, whose propagate is zero.
    assign p_out = 1'b0;
  end else begin : g_black
    assign p_out = p_hi & p_lo;
  end
endmodule

// File: rtl/pfx_network.sv
module pfx_network #(
  parameter int             WIDTH = 64,
  parameter pfx_pkg::topo_e TOPO  = pfx_pkg::TOPO_KOGGE_STONE
) (
  input  logic [WIDTH-1:0] g_in,
  input  logic [WIDTH-1:0] p_in,
  output logic [WIDTH-1:0] g_pre
);
  localparam int LG   = $clog2(WIDTH);
  localparam int LVLS = pfx_pkg::topo_levels(TOPO, LG);

  logic [WIDTH-1:0] g_s [0:LVLS];
  logic [WIDTH-1:0] p_s [0:LVLS];

  assign g_s[0] = g_in;
  assign p_s[0] = p_in;

  for (genvar lv = 1; lv <= LVLS; lv++) begin : g_lvl
    for (genvar bi = 0; bi < WIDTH; bi++) begin : g_lane
      localparam int J  = pfx_pkg::partner(TOPO, LG, lv, bi);
      localparam bit GR = (J >= 0) && (pfx_pkg::span_low(TOPO, LG, lv, bi) == 0);
      if (J < 0) begin : g_wire
        assign g_s[lv][bi] = g_s[lv-1][bi];
        assign p_s[lv][bi] = p_s[lv-1][bi];
      end else begin : g_node
        pfx_cell #(.GRAY(GR)) u_cell (
          .g_hi (g_s[lv-1][bi]),
          .p_hi (p_s[lv-1][bi]),
          .g_lo (g_s[lv-1][J]),
          .p_lo (p_s[lv-1][J]),
          .g_out(g_s[lv][bi]),
          .p_out(p_s[lv][bi])
        );
      end
    end
  end

  assign g_pre = g_s[LVLS];
endmodule

// File: rtl/pfx_adder.sv
module pfx_adder #(
  parameter int             WIDTH = 64,
  parameter pfx_pkg::topo_e TOPO  = pfx_pkg::TOPO_KOGGE_STONE
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  logic [WIDTH-1:0] g_bit;
  logic [WIDTH-1:0] p_bit;
  logic             g0_fold;
  logic             p0_fold;
  logic [WIDTH-1:0] g_net;
  logic [WIDTH-1:0] p_net;
  logic [WIDTH-1:0] g_pre;
  logic [WIDTH-1:0] carry;

  pfx_pg #(.WIDTH(WIDTH)) u_pg (
    .a(a), .b(b), .g(g_bit), .p(p_bit)
  );

  // Merge the carry-in (a generate-only lane below bit 0) into bit 0.
  pfx_cell #(.GRAY(1'b1)) u_fold (
    .g_hi(g_bit[0]), .p_hi(p_bit[0]), .g_lo(cin), .p_lo(1'b0),
    .g_out(g0_fold), .p_out(p0_fold)
  );

  assign g_net = {g_bit[WIDTH-1:1], g0_fold};
  assign p_net = {p_bit[WIDTH-1:1], p0_fold};

  pfx_network #(.WIDTH(WIDTH), .TOPO(TOPO)) u_net (
    .g_in(g_net), .p_in(p_net), .g_pre(g_pre)
  );

  assign carry = {g_pre[WIDTH-2:0], cin};
  assign sum   = p_bit ^ carry;
  assign cout  = g_pre[WIDTH-1];
endmodule

// File: rtl/pfx_adder_chk.sv
module pfx_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout
);
  logic [WIDTH:0] ref_sum;
  assign ref_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  always_comb begin
    if (!$isunknown({a, b, cin, sum, cout})) begin
      p_behav_sum_r1: assert ({cout, sum} == ref_sum);
      if (((a ^ b) == {WIDTH{1'b1}}) && cin)
        p_full_ripple_r3: assert (sum == '0 && cout);
      if (a == '0 && b == '0)
        p_zero_ops_r4: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout);
      if (a[WIDTH-1] && b[WIDTH-1])
        p_msb_gen_r5: assert (cout);
      if (!a[WIDTH-1] && !b[WIDTH-1])
        p_msb_kill_r5: assert (!cout);
      if (b == '0 && !cin)
        p_identity_r6: assert (sum == a && !cout);
    end
  end
endmodule

bind pfx_adder pfx_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/pfx_adder_bench.sv
module pfx_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIDE = 64;
  localparam int NARROW = 8;

  typedef struct packed {
    logic [63:0] a;
    logic [63:0] b;
    logic        c;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001, 1'b0},
    '{64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1},
    '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b0},
    '{64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 1'b1},
    '{64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0},
    '{64'hDEAD_BEEF_CAFE_F00D, 64'h1357_9BDF_2468_ACE0, 1'b1},
    '{64'hFFFF_FFFF_0000_0000, 64'h0000_0001_FFFF_FFFF, 1'b1},
    '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b0}
  };

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [WIDE-1:0] a_in = '0;
  logic [WIDE-1:0] b_in = '0;
  logic            c_in = 1'b0;

  logic [WIDE-1:0]   sum_w  [4];
  logic              cout_w [4];
  logic [NARROW-1:0] sum_n  [4];
  logic              cout_n [4];

  for (genvar t = 0; t < 4; t++) begin : g_wide
    pfx_adder #(.WIDTH(WIDE), .TOPO(pfx_pkg::topo_e'(t))) u_pfx_adder (
      .a(a_in), .b(b_in), .cin(c_in), .sum(sum_w[t]), .cout(cout_w[t])
    );
  end
  for (genvar t = 0; t < 4; t++) begin : g_narrow
    pfx_adder #(.WIDTH(NARROW), .TOPO(pfx_pkg::topo_e'(t))) u_pfx_adder (
      .a(a_in[NARROW-1:0]), .b(b_in[NARROW-1:0]), .cin(c_in),
      .sum(sum_n[t]), .cout(cout_n[t])
    );
  end

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  task automatic check(string req, int topo, logic [64:0] act, logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s topo=%0d actual=%h expected=%h", req, topo, act, exp);
    end
  endtask

  // Drive between edges, judge after the following edge.
  task automatic apply(string req, logic [63:0] va, logic [63:0] vb, logic vc);
    logic [64:0] exp_w;
    logic [64:0] exp_n;
    @(negedge clk);
    a_in = va; b_in = vb; c_in = vc;
    @(posedge clk);
    #1;
    exp_w = {1'b0, va} + {1'b0, vb} + {64'd0, vc};
    exp_n = {56'd0, ({1'b0, va[7:0]} + {1'b0, vb[7:0]} + {8'd0, vc})};
    for (int t = 0; t < 4; t++) begin
      check({req, " R2"}, t, {cout_w[t], sum_w[t]}, exp_w);
      check({req, " R7"}, t, {56'd0, cout_n[t], sum_n[t]}, exp_n);
    end
  endtask

  initial begin
    logic [63:0] ra;
    logic [63:0] rb;
    // R4: settled state with quiet inputs.
    #1;
    for (int t = 0; t < 4; t++)
      check("R4 idle", t, {cout_w[t], sum_w[t]}, 65'd0);

    // R1: table walk.
    for (int k = 0; k < 8; k++)
      apply("R1 table", VECS[k].a, VECS[k].b, VECS[k].c);

    // R4: zero operands with both carry-in values.
    apply("R4 zero cin0", 64'd0, 64'd0, 1'b0);
    apply("R4 zero cin1", 64'd0, 64'd0, 1'b1);

    // R3: carry-in ripples end to end while cout forms.
    apply("R3 ones+0+1", '1, 64'd0, 1'b1);
    apply("R3 alt+1", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1);
    apply("R3 alt0", 64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
    apply("R3 alt swap", 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1);

    // R5: top-bit generate and kill.
    apply("R5 ones+ones", '1, '1, 1'b1);
    apply("R5 msb gen", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    apply("R5 msb kill", 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1'b1);

    // R6: identity with zero addend.
    apply("R6 identity", 64'hC3A5_5A3C_0F0F_F0F0, 64'd0, 1'b0);
    apply("R6 identity ones", '1, 64'd0, 1'b0);

    // R1: random operands.
    for (int k = 0; k < 300; k++) begin
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply("R1 random", ra, rb, 1'($urandom));
    end

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule